// File: doc/BRIEF.md
# Dual-Port Burst-of-Two DDR SRAM Model

This block is a cycle-accurate, synthesizable front end for a quad-data-rate style memory, backed by a behavioural storage array. It has a write data port and a read data port that work independently of each other. Both ports share one address bus. Every address holds a pair of 18-bit words, and both words of the pair always move together on two consecutive half-cycles.

The block runs on one internal clock at twice the command rate. A phase flag, `k_phase`, marks which edges stand for the primary rising instant (high) and which stand for the complementary rising instant (low). The flag alternates on every edge. Read and write commands are sampled only on primary edges:

- **Read.** The read address is captured on the primary edge.
- **Write.** The lower write word is captured on the primary edge. The write address and the upper word follow on the next complementary edge.

Completed writes wait in a one-entry staging register before they reach the array. Reads compare their address against this entry, so they always return the newest data, merged lane by lane.

Top module: `qb2_sram_core`

## Requirements
- R1: `rd_sel_n` and `wr_sel_n` are active low and are sampled only on edges where `k_phase` is 1. Driving them low while `k_phase` is 0 starts no read and changes no stored data.
- R2: The shared `addr` bus carries the read address on the `k_phase`=1 edge and the write address on the following `k_phase`=0 edge. Each operation uses only its own half. Addresses 0 and DEPTH-1 are both reachable.
- R3: A read captured on edge t returns the lower word of the pair on `rd_data` after edge t+RD_LAT_HALF and the upper word after edge t+RD_LAT_HALF+1. `rd_valid` is 1 during exactly those two half-cycles. `rd_data` is 0 whenever `rd_valid` is 0.
- R4: A write is started by `wr_sel_n`=0 on a `k_phase`=1 edge. That edge takes the lower word from `wr_data`. The next edge takes the upper word. Each word has its own `byte_wr_n` value, which is active low: bit 0 enables bits 8:0 and bit 1 enables bits 17:9. A lane whose enable is 1 (high) keeps its old contents.
- R5: A read and a write may start in the same cycle at different addresses, and neither disturbs the other. A read issued every cycle gives an unbroken stream of valid words.
- R6: A read returns every write whose address edge came before the read's edge, merged lane by lane. This holds even when that write is still in staging and has not yet reached the array.
- R7: A write started in the same cycle as a read to the same address is not seen by that read. It is seen by the next read.
- R8: Synchronous active-low reset clears `rd_valid`, `rd_data` and any read still in flight. Contents already committed to the array survive reset.
- R9: A cycle with `wr_sel_n` high, or a write with both lanes of both words disabled, leaves the stored pair unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate internal clock |
| rst_n | input | 1 | Synchronous reset, active low |
| k_phase | input | 1 | 1 on primary edges, 0 on complementary edges; alternates each edge |
| rd_sel_n | input | 1 | Read select, active low, sampled when k_phase=1 |
| wr_sel_n | input | 1 | Write select, active low, sampled when k_phase=1 |
| addr | input | $clog2(DEPTH) | Shared address: read on primary edge, write on complementary edge |
| byte_wr_n | input | 2 | Active-low lane enables for the word on the bus |
| wr_data | input | 18 | Write word: lower word on primary edge, upper word on complementary edge |
| rd_data | output | 18 | Read word, lower word then upper word |
| rd_valid | output | 1 | High during both read-data half-cycles |

## Verification
The bench builds the block with DEPTH=64 and RD_LAT_HALF=3. The small depth lets a short run write and read back both address 0 and the top address, 63, alongside the interior addresses. The latency of three half-cycles puts the upper word of one read right against the lower word of the next read, so back-to-back reads check that the output stream has no gap and no overlap. Reads placed one cycle after a write reach the staging entry before it commits. Reads placed in the same cycle as a write reach the ordering case where the new data must not yet be visible.

// File: rtl/qb2_pkg.sv
// qb2_pkg: shared widths and types for the burst-of-two DDR SRAM model.
// Assumes an 18-bit word split into two equal 9-bit lanes.
package qb2_pkg;
    localparam int DATA_W = 18;
    localparam int LANES  = 2;
    localparam int LANE_W = DATA_W / LANES;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_en_t;

    // One complete write burst: both words and their active-high lane enables.
    typedef struct packed {
        word_t    lo;
        word_t    hi;
        lane_en_t en_lo;
        lane_en_t en_hi;
    } burst_t;
endpackage

// File: rtl/qb2_wr_stage.sv
// qb2_wr_stage: collects a two-word write burst over a primary/complementary
// edge pair and parks it in a one-entry staging register.
// Assumes k_phase alternates every clk edge. The staged entry is released to
// the array (commit_en) when the next burst completes, or on a primary edge
// with no write requested.
module qb2_wr_stage
    import qb2_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              k_phase,
    input  logic              wr_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wr_data,
    input  lane_en_t          byte_wr_n,
    output logic              stg_valid,
    output logic [ADDR_W-1:0] stg_addr,
    output burst_t            stg_burst,
    output logic              commit_en
);
    logic     wr_pend;
    word_t    lo_q;
    lane_en_t lo_en_q;

    // Capture the lower word and its lane enables when a write starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pend <= 1'b0;
            lo_q    <= '0;
            lo_en_q <= '0;
        end else if (k_phase) begin
            wr_pend <= !wr_sel_n;
            if (!wr_sel_n) begin
                lo_q    <= wr_data;
                lo_en_q <= ~byte_wr_n;
            end
        end else begin
            wr_pend <= 1'b0;
        end
    end

    // Release the staged entry on a new burst's completion or an idle primary edge.
    assign commit_en = stg_valid && (k_phase ? wr_sel_n : wr_pend);

    // Load the staging entry on the complementary edge that completes a burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_valid <= 1'b0;
            stg_addr  <= '0;
            stg_burst <= '0;
        end else if (!k_phase && wr_pend) begin
            stg_valid       <= 1'b1;
            stg_addr        <= addr;
            stg_burst.lo    <= lo_q;
            stg_burst.en_lo <= lo_en_q;
            stg_burst.hi    <= wr_data;
            stg_burst.en_hi <= ~byte_wr_n;
        end else if (commit_en) begin
            stg_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/qb2_array.sv
// qb2_array: lane-sliced storage for word pairs, with a coherent lookup that
// overlays the staged burst onto the stored pair lane by lane.
// Assumes DEPTH is a power of two. Storage is not reset.
module qb2_array
    import qb2_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              commit_en,
    input  logic              stg_valid,
    input  logic [ADDR_W-1:0] stg_addr,
    input  burst_t            stg_burst,
    input  logic [ADDR_W-1:0] look_addr,
    output word_t             look_lo,
    output word_t             look_hi
);
    logic hit;

    // The lookup address matches a staged burst.
    assign hit = stg_valid && (stg_addr == look_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int BASE = g * LANE_W;
        logic [LANE_W-1:0] lo_mem [DEPTH];
        logic [LANE_W-1:0] hi_mem [DEPTH];

        // Commit the enabled lanes of the staged burst.
        always_ff @(posedge clk) begin
            if (commit_en && stg_burst.en_lo[g]) begin
                lo_mem[stg_addr] <= stg_burst.lo[BASE +: LANE_W];
            end
            if (commit_en && stg_burst.en_hi[g]) begin
                hi_mem[stg_addr] <= stg_burst.hi[BASE +: LANE_W];
            end
        end

        // Newest data per lane: staged lane when enabled, stored lane otherwise.
        assign look_lo[BASE +: LANE_W] = (hit && stg_burst.en_lo[g]) ?
                                         stg_burst.lo[BASE +: LANE_W] : lo_mem[look_addr];
        assign look_hi[BASE +: LANE_W] = (hit && stg_burst.en_hi[g]) ?
                                         stg_burst.hi[BASE +: LANE_W] : hi_mem[look_addr];
    end
endmodule

// File: rtl/qb2_rd_pipe.sv
// qb2_rd_pipe: delays a looked-up word pair by RD_LAT_HALF half-cycles, then
// serialises it lower word first onto rd_data, with rd_valid high for both words.
// Assumes RD_LAT_HALF >= 2 and at most one read per two edges.
module qb2_rd_pipe
    import qb2_pkg::*;
#(
    parameter int RD_LAT_HALF = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rd_go,
    input  word_t look_lo,
    input  word_t look_hi,
    output word_t rd_data,
    output logic  rd_valid
);
    localparam int LAST = RD_LAT_HALF - 1;

    logic [RD_LAT_HALF-1:0] v_q;
    word_t                  lo_q [RD_LAT_HALF];
    word_t                  hi_q [RD_LAT_HALF];
    word_t                  hold_q;
    logic                   second_q;

    // Delay line for the read flag and the looked-up pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            for (int i = 0; i < RD_LAT_HALF; i++) begin
                lo_q[i] <= '0;
                hi_q[i] <= '0;
            end
        end else begin
            v_q     <= {v_q[RD_LAT_HALF-2:0], rd_go};
            lo_q[0] <= look_lo;
            hi_q[0] <= look_hi;
            for (int i = 1; i < RD_LAT_HALF; i++) begin
                lo_q[i] <= lo_q[i-1];
                hi_q[i] <= hi_q[i-1];
            end
        end
    end

    // Drive the lower word, then the held upper word; zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            hold_q   <= '0;
            second_q <= 1'b0;
        end else if (v_q[LAST]) begin
            rd_data  <= lo_q[LAST];
            hold_q   <= hi_q[LAST];
            second_q <= 1'b1;
            rd_valid <= 1'b1;
        end else if (second_q) begin
            rd_data  <= hold_q;
            second_q <= 1'b0;
            rd_valid <= 1'b1;
        end else begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/qb2_sram_core.sv
// qb2_sram_core: dual-port burst-of-two DDR SRAM model. It joins write
// staging, coherent storage and the read delay line.
// Assumes k_phase alternates on every clk edge, with 1 marking primary edges.
module qb2_sram_core
    import qb2_pkg::*;
#(
    parameter int DEPTH       = 1024,
    parameter int RD_LAT_HALF = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     k_phase,
    input  logic                     rd_sel_n,
    input  logic                     wr_sel_n,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [LANES-1:0]         byte_wr_n,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     rd_valid
);
    localparam int ADDR_W = $clog2(DEPTH);

    logic              stg_valid;
    logic [ADDR_W-1:0] stg_addr;
    burst_t            stg_burst;
    logic              commit_en;
    logic              rd_go;
    word_t             look_lo;
    word_t             look_hi;

    // A read starts only on a primary edge with the select low.
    assign rd_go = k_phase && !rd_sel_n;

    qb2_wr_stage #(.ADDR_W(ADDR_W)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .k_phase   (k_phase),
        .wr_sel_n  (wr_sel_n),
        .addr      (addr),
        .wr_data   (wr_data),
        .byte_wr_n (byte_wr_n),
        .stg_valid (stg_valid),
        .stg_addr  (stg_addr),
        .stg_burst (stg_burst),
        .commit_en (commit_en)
    );

    qb2_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_arr (
        .clk       (clk),
        .commit_en (commit_en),
        .stg_valid (stg_valid),
        .stg_addr  (stg_addr),
        .stg_burst (stg_burst),
        .look_addr (addr),
        .look_lo   (look_lo),
        .look_hi   (look_hi)
    );

    qb2_rd_pipe #(.RD_LAT_HALF(RD_LAT_HALF)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_go    (rd_go),
        .look_lo  (look_lo),
        .look_hi  (look_hi),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );
endmodule

// File: rtl/qb2_sram_chk.sv
// qb2_sram_chk: property checker bound to qb2_sram_core. It tracks read
// starts from the ports and checks the output timing, phase alternation and
// write staging.
module qb2_sram_chk #(
    parameter int RD_LAT_HALF = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        k_phase,
    input logic        rd_sel_n,
    input logic        wr_sel_n,
    input logic [17:0] rd_data,
    input logic        rd_valid,
    input logic        stg_valid
);
    logic [RD_LAT_HALF:0] issue_q;
    logic                 wp_q;
    logic                 prev_q;
    logic                 seen_q;

    // Port-level record of read starts, write starts and the previous phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_q <= '0;
            wp_q    <= 1'b0;
            prev_q  <= 1'b0;
            seen_q  <= 1'b0;
        end else begin
            issue_q <= {issue_q[RD_LAT_HALF-1:0], k_phase && !rd_sel_n};
            wp_q    <= k_phase && !wr_sel_n;
            prev_q  <= k_phase;
            seen_q  <= 1'b1;
        end
    end

    p_phase_alternates_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (k_phase != prev_q));

    p_read_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_q[RD_LAT_HALF-1] || issue_q[RD_LAT_HALF]) |=> rd_valid);

    p_no_spurious_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_q[RD_LAT_HALF-1] || issue_q[RD_LAT_HALF]) |=> !rd_valid);

    p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == 18'd0));

    p_burst_staged_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_q && !k_phase) |=> stg_valid);
endmodule

bind qb2_sram_core qb2_sram_chk #(.RD_LAT_HALF(RD_LAT_HALF)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .k_phase   (k_phase),
    .rd_sel_n  (rd_sel_n),
    .wr_sel_n  (wr_sel_n),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .stg_valid (stg_valid)
);

// File: tb/sim_qb2_sram_core.sv
`timescale 1ns/1ps
// sim_qb2_sram_core: behavioural reference model compared against the outputs
// every half-cycle.
module sim_qb2_sram_core;
    localparam int DEPTH = 64;
    localparam int AW    = 6;
    localparam int LAT   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          k_phase = 1'b0;
    logic          rd_sel_n = 1'b1;
    logic          wr_sel_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [1:0]    byte_wr_n = 2'b11;
    logic [17:0]   wr_data = '0;
    logic [17:0]   rd_data;
    logic          rd_valid;

    int    n_checks = 0;
    int    n_fails  = 0;
    string cur_req  = "R8";
    bit    done     = 1'b0;

    always #2.5 clk = ~clk;

    qb2_sram_core #(.DEPTH(DEPTH), .RD_LAT_HALF(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .k_phase(k_phase), .rd_sel_n(rd_sel_n),
        .wr_sel_n(wr_sel_n), .addr(addr), .byte_wr_n(byte_wr_n),
        .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // Reference state: stored pairs, scheduled outputs, pending write.
    logic [17:0] ref_lo [int];
    logic [17:0] ref_hi [int];
    logic [17:0] exp_q  [int];
    int          hc = 0;
    bit          last_rst = 1'b1;
    bit          started = 1'b0;
    bit          w_pend = 1'b0;
    logic [17:0] w_lo;
    logic [1:0]  w_en_lo;

    function automatic logic [17:0] lane_pick(logic [17:0] old, logic [17:0] nw, logic [1:0] en);
        return {en[1] ? nw[17:9] : old[17:9], en[0] ? nw[8:0] : old[8:0]};
    endfunction

    // Model update on every edge.
    always @(posedge clk) begin
        started  = 1'b1;
        last_rst = !rst_n;
        if (!rst_n) begin
            hc = 0;
            w_pend = 1'b0;
            exp_q.delete();
        end else begin
            if (k_phase) begin
                if (!rd_sel_n) begin
                    exp_q[hc+LAT]   = ref_lo.exists(int'(addr)) ? ref_lo[int'(addr)] : 18'hx;
                    exp_q[hc+LAT+1] = ref_hi.exists(int'(addr)) ? ref_hi[int'(addr)] : 18'hx;
                end
                w_pend = !wr_sel_n;
                if (!wr_sel_n) begin
                    w_lo    = wr_data;
                    w_en_lo = ~byte_wr_n;
                end
            end else begin
                if (w_pend) begin
                    ref_lo[int'(addr)] = lane_pick(ref_lo.exists(int'(addr)) ? ref_lo[int'(addr)] : 18'hx,
                                                   w_lo, w_en_lo);
                    ref_hi[int'(addr)] = lane_pick(ref_hi.exists(int'(addr)) ? ref_hi[int'(addr)] : 18'hx,
                                                   wr_data, ~byte_wr_n);
                end
                w_pend = 1'b0;
            end
            hc++;
        end
    end

    task automatic chk(input bit ok, input string what, input logic [18:0] act, input logic [18:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Output comparison away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            if (last_rst) begin
                chk(rd_valid === 1'b0 && rd_data === 18'd0, "reset outputs",
                    {rd_valid, rd_data}, 19'd0);
            end else if (exp_q.exists(hc-1)) begin
                chk(rd_valid === 1'b1 && rd_data === exp_q[hc-1], "read word",
                    {rd_valid, rd_data}, {1'b1, exp_q[hc-1]});
                exp_q.delete(hc-1);
            end else begin
                chk(rd_valid === 1'b0 && rd_data === 18'd0, "idle outputs",
                    {rd_valid, rd_data}, 19'd0);
            end
        end
    end

    // One command cycle: primary half, then complementary half.
    task automatic cyc(input bit rn, input int ra, input bit wn, input int wa,
                       input logic [17:0] lo, input logic [1:0] elo,
                       input logic [17:0] hi, input logic [1:0] ehi,
                       input bit rn2 = 1'b1, input bit wn2 = 1'b1);
        @(negedge clk);
        k_phase = 1'b1; rd_sel_n = rn; wr_sel_n = wn;
        addr = ra[AW-1:0]; wr_data = lo; byte_wr_n = ~elo;
        @(negedge clk);
        k_phase = 1'b0; rd_sel_n = rn2; wr_sel_n = wn2;
        addr = wa[AW-1:0]; wr_data = hi; byte_wr_n = ~ehi;
    endtask

    task automatic wr(input int a, input logic [17:0] lo, input logic [17:0] hi,
                      input logic [1:0] elo = 2'b11, input logic [1:0] ehi = 2'b11);
        cyc(1'b1, ~a, 1'b0, a, lo, elo, hi, ehi);
    endtask

    task automatic rd(input int a);
        cyc(1'b0, a, 1'b1, ~a, 18'h0, 2'b00, 18'h0, 2'b00);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 0, 1'b1, 0, 18'h0, 2'b00, 18'h0, 2'b00);
    endtask

    initial begin
        cur_req = "R8";
        idle(3);
        rst_n = 1'b1;
        idle(1);

        cur_req = "R4";
        wr(5, 18'h12345, 18'h2ABCD);
        wr(6, 18'h0F0F0, 18'h30303);
        wr(7, 18'h3FFFF, 18'h00001);
        wr(7, 18'h00000, 18'h3FFFF, 2'b01, 2'b10);
        cur_req = "R2";
        wr(0, 18'h11111, 18'h22222);
        wr(63, 18'h3C3C3, 18'h1E1E1);
        idle(1);

        cur_req = "R3";
        rd(5); rd(6); rd(7); rd(0); rd(63);
        idle(3);

        cur_req = "R1";
        cyc(1'b1, 5, 1'b1, 5, 18'h2DEAD, 2'b11, 18'h2BEEF, 2'b11, 1'b0, 1'b0);
        idle(3);
        rd(5);
        idle(3);

        cur_req = "R6";
        wr(9, 18'h0AAAA, 18'h15555);
        rd(9);
        wr(9, 18'h3FFFF, 18'h3FFFF, 2'b01, 2'b00);
        rd(9);
        wr(10, 18'h01234, 18'h05678);
        wr(9, 18'h00000, 18'h00000, 2'b10, 2'b10);
        rd(9); rd(10);
        idle(3);

        cur_req = "R7";
        cyc(1'b0, 5, 1'b0, 5, 18'h0BEAD, 2'b11, 18'h0CAFE, 2'b11);
        rd(5);
        idle(3);

        cur_req = "R5";
        cyc(1'b0, 6, 1'b0, 20, 18'h00AAA, 2'b11, 18'h00BBB, 2'b11);
        cyc(1'b0, 20, 1'b0, 21, 18'h00CCC, 2'b11, 18'h00DDD, 2'b11);
        cyc(1'b0, 21, 1'b0, 6, 18'h33333, 2'b11, 18'h24924, 2'b11);
        cyc(1'b0, 6, 1'b1, 0, 18'h0, 2'b00, 18'h0, 2'b00);
        idle(3);

        cur_req = "R9";
        cyc(1'b1, 6, 1'b1, 6, 18'h3ABCD, 2'b11, 18'h3DCBA, 2'b11);
        rd(6);
        wr(6, 18'h01010, 18'h02020, 2'b00, 2'b00);
        idle(1);
        rd(6);
        idle(3);

        cur_req = "R8";
        wr(11, 18'h13579, 18'h2468A);
        idle(3);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        rd(11);
        idle(4);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(100000 * 5.0);
        if (!done) begin
            done = 1'b1;
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule